// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

The block gathers three reset requests and turns them into one system reset and one externally visible reset indication. The requests are an external reset pin, a one-cycle timeout pulse from a watchdog, and a reset request on a general-purpose pin. All of its logic runs from a slow, always-on timebase clock of 32.768 kHz. The three pins that enter from outside the timebase domain each pass through a two-stage synchroniser, and the external reset pin also passes through a glitch filter.

Any accepted request drives both reset outputs low at once. After the last request goes away, the indication stays low for a fixed stretch of `STRETCH` timebase cycles (594 cycles, about 18.13 ms). At the end of the stretch the indication always rises. The system reset rises only if both active-low power-fault inputs were high during the last cycle in which a request was active. Otherwise the block keeps the system in reset and raises a sleep request.

The general-purpose pin acts as a reset only while its reset-function flag is set. The flag is cleared as soon as that reset takes effect. A 2-bit cause register records which source acted most recently.

Top module: `rst_seq`

## Requirements
- R1: While `por_n` is low, `reset_out_n` and `sys_rst_n` are low, `sleep_req` is low, `gpio_reset_fn_en` is high and `rst_cause` is 00. After `por_n` rises, both resets rise at the `STRETCH`-th rising edge of `clk_tb`.
- R2: The external pin counts as a reset only if its synchronised value is low at `FILT_LEN` (2) consecutive rising edges. A low pulse lasting a single cycle changes no output.
- R3: A valid external reset drives `reset_out_n` and `sys_rst_n` low at the 5th rising edge after the pin falls: two synchroniser edges, two filter edges and one output edge.
- R4: `reset_out_n` rises exactly `STRETCH` rising edges after the last edge at which any request was active. For the external pin, this is the (`STRETCH`+3)-th edge after the pin rises.
- R5: A watchdog pulse that is high at one rising edge drives both resets low at that edge. `reset_out_n` then rises `STRETCH` edges later.
- R6: A new request that arrives while the stretch is counting restarts the stretch from zero. Only one stretch is ever active.
- R7: Both fault inputs pass through a two-stage synchroniser and are sampled in the last active request cycle. If either input was low, then at the end of the stretch `reset_out_n` rises, `sys_rst_n` stays low and `sleep_req` goes high. `sleep_req` clears when the next request starts. A power-on reset always releases into run.
- R8: While `gpio_reset_fn_en` is high, a general-purpose pin that is low at two synchronised edges causes a reset at the 3rd edge after it falls. `gpio_reset_fn_en` clears at that same edge. After that, the pin has no effect until an external reset sets the flag again.
- R9: `rst_cause` is 01 for the external pin, 10 for the watchdog and 11 for the general-purpose pin. It holds its value until the next request. When requests coincide, the external pin has priority over the watchdog, and the watchdog over the general-purpose pin.
- R10: `sys_rst_n` is never high while `reset_out_n` is low, and `sleep_req` and `sys_rst_n` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tb | input | 1 | Always-on timebase clock (32.768 kHz) |
| por_n | input | 1 | Power-on reset of the sequencer itself, asynchronous, active low |
| hw_rst_n | input | 1 | External reset pin, asynchronous, active low |
| wdt_pulse | input | 1 | Watchdog timeout, one cycle long, synchronous to `clk_tb` |
| gpio_rst_n | input | 1 | General-purpose pin used as a reset request, asynchronous, active low |
| batt_flt_n | input | 1 | Battery fault, asynchronous, active low |
| vdd_flt_n | input | 1 | Core supply fault, asynchronous, active low |
| sys_rst_n | output | 1 | System reset, active low |
| reset_out_n | output | 1 | External reset indication, active low |
| sleep_req | output | 1 | Request to enter sleep instead of run |
| gpio_reset_fn_en | output | 1 | The general-purpose pin still acts as a reset |
| rst_cause | output | 2 | Source of the most recent reset |

## Verification
The assertions assume that `wdt_pulse` is synchronous to `clk_tb` and lasts one cycle. They also assume that `por_n` is held low across the first clock edges, so that the stretch counter in the checker starts out aligned with the design. The stimulus meets both assumptions. It changes every input half a period away from the rising edge and drives the watchdog for exactly one cycle. It holds the fault inputs steady from several cycles before a request until after the release check, so that the sampled fault value is the one the bench expects.

// File: rtl/rst_seq.sv
`timescale 1ns/1ps
module rst_seq #(
  parameter int STRETCH  = 594,
  parameter int FILT_LEN = 2,
  parameter int SYNC     = 2
) (
  input  logic       clk_tb,
  input  logic       por_n,
  input  logic       hw_rst_n,
  input  logic       wdt_pulse,
  input  logic       gpio_rst_n,
  input  logic       batt_flt_n,
  input  logic       vdd_flt_n,
  output logic       sys_rst_n,
  output logic       reset_out_n,
  output logic       sleep_req,
  output logic       gpio_reset_fn_en,
  output logic [1:0] rst_cause
);
  localparam int CW = $clog2(STRETCH);
  localparam int FW = $clog2(FILT_LEN + 1);
  localparam logic [1:0] CAUSE_HW   = 2'b01;
  localparam logic [1:0] CAUSE_WDT  = 2'b10;
  localparam logic [1:0] CAUSE_GPIO = 2'b11;

  logic [3:0]           pin_raw;
  logic [3:0][SYNC-1:0] shf;
  logic [3:0]           pin_s;
  logic [FW-1:0]        flt_cnt;
  logic [CW-1:0]        cnt;
  logic                 busy, flt_bad;
  logic                 hw_act, gp_act, req;

  assign pin_raw = {hw_rst_n, gpio_rst_n, batt_flt_n, vdd_flt_n};

  always_ff @(posedge clk_tb or negedge por_n)
    if (!por_n) shf <= '1;
    else for (int i = 0; i < 4; i++) shf[i] <= {shf[i][SYNC-2:0], pin_raw[i]};

  for (genvar g = 0; g < 4; g++) begin : g_pin
    assign pin_s[g] = shf[g][SYNC-1];
  end

  always_ff @(posedge clk_tb or negedge por_n)
    if (!por_n)            flt_cnt <= '0;
    else if (pin_s[3])     flt_cnt <= '0;
    else if (!hw_act)      flt_cnt <= flt_cnt + 1'b1;

  assign hw_act = (flt_cnt == FW'(FILT_LEN));
  assign gp_act = gpio_reset_fn_en & ~pin_s[2];
  assign req    = hw_act | wdt_pulse | gp_act;

  always_ff @(posedge clk_tb or negedge por_n)
    if (!por_n) begin
      busy             <= 1'b1;
      cnt              <= '0;
      reset_out_n      <= 1'b0;
      sys_rst_n        <= 1'b0;
      sleep_req        <= 1'b0;
      flt_bad          <= 1'b0;
      gpio_reset_fn_en <= 1'b1;
      rst_cause        <= 2'b00;
    end else if (req) begin
      busy        <= 1'b1;
      cnt         <= '0;
      reset_out_n <= 1'b0;
      sys_rst_n   <= 1'b0;
      sleep_req   <= 1'b0;
      flt_bad     <= ~(pin_s[1] & pin_s[0]);
      if (hw_act)         rst_cause <= CAUSE_HW;
      else if (wdt_pulse) rst_cause <= CAUSE_WDT;
      else                rst_cause <= CAUSE_GPIO;
      if (hw_act)         gpio_reset_fn_en <= 1'b1;
      else if (gp_act)    gpio_reset_fn_en <= 1'b0;
    end else if (busy) begin
      if (cnt == CW'(STRETCH - 1)) begin
        busy        <= 1'b0;
        reset_out_n <= 1'b1;
        sys_rst_n   <= ~flt_bad;
        sleep_req   <= flt_bad;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
endmodule

module rst_seq_chk #(
  parameter int STRETCH = 594
) (
  input logic clk,
  input logic por_n,
  input logic req,
  input logic wdt_pulse,
  input logic reset_out_n,
  input logic sys_rst_n,
  input logic sleep_req,
  input logic fn_en
);
  logic [31:0] quiet;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)            quiet <= '0;
    else if (req)          quiet <= '0;
    else if (!reset_out_n) quiet <= quiet + 1;

  assert_run_after_out_R10: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_n |-> reset_out_n);
  assert_sleep_excl_R10: assert property (@(posedge clk) disable iff (!por_n)
    !(sleep_req && sys_rst_n));
  assert_wdt_asserts_R5: assert property (@(posedge clk) disable iff (!por_n)
    wdt_pulse |=> !reset_out_n);
  assert_stretch_len_R4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(reset_out_n) |-> (quiet == STRETCH));
  assert_fn_drop_R8: assert property (@(posedge clk) disable iff (!por_n)
    $fell(fn_en) |-> !reset_out_n);
  assert_sleep_at_release_R7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sleep_req) |-> $rose(reset_out_n));
endmodule

bind rst_seq rst_seq_chk #(.STRETCH(STRETCH)) u_chk (
  .clk(clk_tb), .por_n(por_n), .req(req), .wdt_pulse(wdt_pulse),
  .reset_out_n(reset_out_n), .sys_rst_n(sys_rst_n), .sleep_req(sleep_req),
  .fn_en(gpio_reset_fn_en)
);

// File: tb/rst_seq_bench.sv
`timescale 1ns/1ps
module rst_seq_bench;
  localparam int S = 594;

  logic clk = 1'b0;
  logic por_n = 1'b0, hw_rst_n = 1'b1, wdt_pulse = 1'b0, gpio_rst_n = 1'b1;
  logic batt_flt_n = 1'b1, vdd_flt_n = 1'b1;
  logic sys_rst_n, reset_out_n, sleep_req, gpio_reset_fn_en;
  logic [1:0] rst_cause;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  rst_seq u_rst_seq (
    .clk_tb(clk), .por_n(por_n), .hw_rst_n(hw_rst_n), .wdt_pulse(wdt_pulse),
    .gpio_rst_n(gpio_rst_n), .batt_flt_n(batt_flt_n), .vdd_flt_n(vdd_flt_n),
    .sys_rst_n(sys_rst_n), .reset_out_n(reset_out_n), .sleep_req(sleep_req),
    .gpio_reset_fn_en(gpio_reset_fn_en), .rst_cause(rst_cause)
  );

  // {kind[1:0] (0 pin, 1 watchdog, 2 gpio), batt, vdd, cause[1:0], sleep}
  localparam logic [6:0] VEC [0:7] = '{
    {2'd0, 1'b1, 1'b1, 2'b01, 1'b0},
    {2'd1, 1'b1, 1'b1, 2'b10, 1'b0},
    {2'd2, 1'b1, 1'b1, 2'b11, 1'b0},
    {2'd0, 1'b0, 1'b1, 2'b01, 1'b1},
    {2'd1, 1'b1, 1'b0, 2'b10, 1'b1},
    {2'd2, 1'b1, 1'b1, 2'b11, 1'b0},
    {2'd0, 1'b0, 1'b0, 2'b01, 1'b1},
    {2'd0, 1'b1, 1'b1, 2'b01, 1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 out during por", reset_out_n, 0);
    chk("R1 sys during por", sys_rst_n, 0);
    chk("R1 sleep during por", sleep_req, 0);
    chk("R1 fn during por", gpio_reset_fn_en, 1);
    chk("R1 cause during por", rst_cause, 0);
    por_n = 1'b1;
    tick(S - 1);
    chk("R1 out before release", reset_out_n, 0);
    tick(1);
    chk("R1 out released", reset_out_n, 1);
    chk("R1 sys released", sys_rst_n, 1);
    chk("R1 cause none", rst_cause, 0);

    for (int v = 0; v < 8; v++) begin
      logic [6:0] e;
      e = VEC[v];
      batt_flt_n = e[4];
      vdd_flt_n  = e[3];
      tick(4);
      case (e[6:5])
        2'd0: begin
          hw_rst_n = 1'b0;
          tick(4);
          chk("R3 pin not yet", reset_out_n, 1);
          tick(1);
          chk("R3 pin asserts out", reset_out_n, 0);
          chk("R3 pin asserts sys", sys_rst_n, 0);
          tick(10);
          hw_rst_n = 1'b1;
          tick(S + 2);
          chk("R4 pin held", reset_out_n, 0);
          tick(1);
          chk("R4 pin release", reset_out_n, 1);
          chk("R8 pin rearms fn", gpio_reset_fn_en, 1);
        end
        2'd1: begin
          wdt_pulse = 1'b1;
          tick(1);
          wdt_pulse = 1'b0;
          chk("R5 wdt asserts", reset_out_n, 0);
          tick(S - 1);
          chk("R5 wdt held", reset_out_n, 0);
          tick(1);
          chk("R5 wdt release", reset_out_n, 1);
        end
        default: begin
          gpio_rst_n = 1'b0;
          tick(2);
          chk("R8 gpio not yet", reset_out_n, 1);
          tick(1);
          chk("R8 gpio asserts", reset_out_n, 0);
          chk("R8 gpio fn cleared", gpio_reset_fn_en, 0);
          tick(5);
          gpio_rst_n = 1'b1;
          tick(S - 6);
          chk("R4 gpio held", reset_out_n, 0);
          tick(1);
          chk("R4 gpio release", reset_out_n, 1);
        end
      endcase
      chk("R7 sleep", sleep_req, {31'd0, e[0]});
      chk("R7 sys", sys_rst_n, {31'd0, !e[0]});
      chk("R9 cause", rst_cause, {30'd0, e[2:1]});
      batt_flt_n = 1'b1;
      vdd_flt_n  = 1'b1;
      tick(4);
    end

    // R6 restart of the stretch by a second watchdog pulse
    wdt_pulse = 1'b1; tick(1); wdt_pulse = 1'b0;
    tick(300);
    wdt_pulse = 1'b1; tick(1); wdt_pulse = 1'b0;
    tick(S - 301);
    chk("R6 no release at first end", reset_out_n, 0);
    tick(300);
    chk("R6 held until second end", reset_out_n, 0);
    tick(1);
    chk("R6 release at second end", reset_out_n, 1);
    chk("R9 watchdog cause", rst_cause, 2'b10);

    // R2 single-cycle glitch on the pin is ignored
    hw_rst_n = 1'b0; tick(1); hw_rst_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      tick(1);
      chk("R2 glitch ignored", reset_out_n, 1);
    end
    chk("R2 glitch keeps cause", rst_cause, 2'b10);

    // R2 boundary: two cycles low is accepted
    hw_rst_n = 1'b0; tick(2); hw_rst_n = 1'b1;
    tick(3);
    chk("R2 two-cycle pulse accepted", reset_out_n, 0);
    tick(S - 1);
    chk("R4 short pulse held", reset_out_n, 0);
    tick(1);
    chk("R4 short pulse release", reset_out_n, 1);

    // R9 priority: watchdog during an active pin reset
    hw_rst_n = 1'b0; tick(6);
    wdt_pulse = 1'b1; tick(1); wdt_pulse = 1'b0;
    tick(1);
    chk("R9 pin beats watchdog", rst_cause, 2'b01);
    hw_rst_n = 1'b1;
    tick(S + 3);
    chk("R10 run after priority", sys_rst_n, 1);

    // R8 gpio pin ignored after its reset took effect
    gpio_rst_n = 1'b0; tick(3);
    chk("R8 gpio reset fires", reset_out_n, 0);
    tick(2); gpio_rst_n = 1'b1;
    tick(S);
    chk("R8 gpio release", reset_out_n, 1);
    gpio_rst_n = 1'b0;
    tick(8);
    chk("R8 gpio ignored when off", reset_out_n, 1);
    chk("R8 fn stays off", gpio_reset_fn_en, 0);
    chk("R9 gpio cause kept", rst_cause, 2'b11);
    gpio_rst_n = 1'b1;
    tick(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule